// File: doc/BRIEF.md
# Interrupt Redirection Controller

This block collects a group of external interrupt lines, groups them into pins, and turns each active pin into an interrupt message. A message carries an 8-bit vector, a 16-bit destination identifier and a 3-bit delivery mode. Each pin has a redirection entry that sets what the message carries and how the pin's input is read: the active level, edge or level triggering, and a mask. Several source lines feed each pin. The pin is active while any one of its sources is active, so level-triggered lines with the same polarity can share a pin.

Software uses three addresses on a simple 32-bit register bus. The first is a select register that holds an index. The second is a window that reads or writes the 32-bit register named by that index. The third is an end-of-interrupt register that is addressed directly. Edge events that arrive while a pin is masked are discarded. A level pin that has been delivered stays quiet until software writes that pin's vector to the end-of-interrupt register. Messages leave on a valid/ready output. When more than one pin is pending, the lowest-numbered pin goes first.

Top module: `irq_redir_ctrl`

## Requirements
- R1: After reset, every pin's low word reads 0x0001_0000 (masked, edge, active-high, all other fields zero), every high word reads zero, and no message is valid.
- R2: Writing offset 0x00 sets the select index, and reading offset 0x00 returns it. Offset 0x10 is the window. Index 0x10+2p selects pin p's low word and 0x11+2p selects its high word. The low word keeps only vector [7:0], delivery mode [10:8], polarity [13], trigger [15] and mask [16]. The high word keeps only the destination [31:16]. Every other bit reads zero. An index with no register behind it reads zero, and window writes to it have no effect.
- R3: Index 0x01 is a read-only version word: the version in [7:0], NUM_PINS-1 in [23:16], and zero in [15:8] and [31:24].
- R4: A read-modify-write that clears only the mask bit leaves every other field of the low word unchanged. A pin whose mask bit is 1 delivers nothing, and clearing the mask re-enables delivery.
- R5: An edge pin (trigger bit 0) delivers one message for each inactive-to-active transition that happens while it is unmasked. A transition that happens while the pin is masked is dropped, and unmasking the pin later produces no message for it.
- R6: A level pin (trigger bit 1) delivers once and then stays silent until a 32-bit write to offset 0x40 carries its vector in bits [7:0]. A write with any other vector has no effect. After the matching write, a pin that is still active is delivered again.
- R7: Polarity bit 0 makes a source active when high, and polarity bit 1 makes it active when low. A pin is active while any of its sources is active.
- R8: A message carries the pin's vector, the destination (high word [31:16]) and the delivery mode, as they stood when the message was launched.
- R9: While valid is high and ready is low, valid stays high and the message fields do not change.
- R10: When several pins are pending, the lowest-numbered pin is sent first. The others stay pending and follow in pin order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read data is combinational) |
| reg_addr | input | 8 | Byte offset: 0x00 select, 0x10 window, 0x40 end-of-interrupt |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, zero when reg_rd is low |
| irq_in | input | NUM_PINS*SRCS_PER_PIN | Source lines; pin p uses lines [p*SRCS_PER_PIN +: SRCS_PER_PIN] |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | The consumer takes the message |
| msg_vector | output | 8 | Message vector |
| msg_dest | output | 16 | Message destination identifier |
| msg_dmode | output | 3 | Message delivery mode |

## Verification
The bench goes after an edge that arrives while its pin is masked. A design that latched that edge would send a message as soon as the pin is unmasked. It writes end-of-interrupt with a vector one off from the pin's vector. A design that matched loosely would re-arm the pin and deliver it a second time. It holds ready low with two level pins asserted on the same cycle. This shows whether the message fields stay put while held and whether the higher-numbered pin waits its turn instead of being lost or sent first. It also sweeps every pin's low and high words with patterns that set reserved bits, which exposes index decoding that is off by one and reserved bits that leak into read data.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

    // Register bus byte offsets
    localparam logic [7:0] OFS_SELECT = 8'h00;
    localparam logic [7:0] OFS_WINDOW = 8'h10;
    localparam logic [7:0] OFS_EOI    = 8'h40;

    // Select-register indices
    localparam logic [7:0] IDX_VERSION    = 8'h01;
    localparam logic [7:0] IDX_ENTRY_BASE = 8'h10;

    // Stored fields of a pin's low word
    typedef struct packed {
        logic [7:0] vector;
        logic [2:0] dmode;
        logic       pol_low;
        logic       trig_level;
        logic       masked;
    } rte_low_t;

    typedef struct packed {
        logic [7:0]  vector;
        logic [15:0] dest;
        logic [2:0]  dmode;
    } irq_msg_t;

    localparam rte_low_t RTE_LOW_RESET = '{vector: 8'h00, dmode: 3'd0,
                                           pol_low: 1'b0, trig_level: 1'b0,
                                           masked: 1'b1};

    function automatic rte_low_t unpack_low(input logic [31:0] w);
        rte_low_t e;
        e.vector     = w[7:0];
        e.dmode      = w[10:8];
        e.pol_low    = w[13];
        e.trig_level = w[15];
        e.masked     = w[16];
        return e;
    endfunction

    function automatic logic [31:0] pack_low(input rte_low_t e);
        logic [31:0] w;
        w        = '0;
        w[7:0]   = e.vector;
        w[10:8]  = e.dmode;
        w[13]    = e.pol_low;
        w[15]    = e.trig_level;
        w[16]    = e.masked;
        return w;
    endfunction

endpackage

// File: rtl/irq_pin_slot.sv
module irq_pin_slot
    import irq_redir_pkg::*;
#(
    parameter int SRCS = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [SRCS-1:0] src,
    input  logic            wr_low,
    input  logic            wr_high,
    input  logic [31:0]     wdata,
    input  logic            eoi_wr,
    input  logic [7:0]      eoi_vec,
    input  logic            take,
    output rte_low_t        low_q,
    output logic [15:0]     dest_q,
    output logic            req
);

    logic active;
    logic prev_active;
    logic rise;
    logic pend;
    logic in_service;
    logic eoi_hit;

    // Any source active, in the selected polarity
    assign active  = low_q.pol_low ? |(~src) : |src;
    assign rise    = active && !prev_active;
    assign eoi_hit = eoi_wr && (eoi_vec == low_q.vector);

    always_ff @(posedge clk) begin
        if (rst) begin
            low_q       <= RTE_LOW_RESET;
            dest_q      <= '0;
            prev_active <= 1'b0;
            pend        <= 1'b0;
            in_service  <= 1'b0;
        end else begin
            if (wr_low)  low_q  <= unpack_low(wdata);
            if (wr_high) dest_q <= wdata[31:16];
            prev_active <= active;

            // Edge capture: dropped while masked, never held for later
            if (low_q.masked || low_q.trig_level) pend <= 1'b0;
            else if (take)                        pend <= rise;
            else if (rise)                        pend <= 1'b1;

            // Level in-service: set at launch, cleared by a matching EOI
            if (!low_q.trig_level) in_service <= 1'b0;
            else if (take)         in_service <= 1'b1;
            else if (eoi_hit)      in_service <= 1'b0;
        end
    end

    assign req = !low_q.masked && (low_q.trig_level ? (active && !in_service) : pend);

    // R1: the first cycle after reset finds the pin masked and idle
    p_reset_masked_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (low_q.masked && !pend && !in_service));

    // R5: an edge seen while masked leaves nothing pending
    p_masked_edge_dropped_r5: assert property (@(posedge clk) disable iff (rst)
        low_q.masked |=> !pend);

    // R6: a delivered level pin stays in service until its EOI
    p_level_waits_eoi_r6: assert property (@(posedge clk) disable iff (rst)
        (in_service && low_q.trig_level && !eoi_hit) |=> in_service);

endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx,
    output logic          any
);

    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant = '0;
                grant[i] = 1'b1;
                idx = IW'(i);
            end
        end
    end

    assign any = |req;

endmodule

// File: rtl/irq_redir_ctrl.sv
module irq_redir_ctrl
    import irq_redir_pkg::*;
#(
    parameter int         NUM_PINS     = 4,
    parameter int         SRCS_PER_PIN = 2,
    parameter logic [7:0] VERSION      = 8'h21
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             reg_wr,
    input  logic                             reg_rd,
    input  logic [7:0]                       reg_addr,
    input  logic [31:0]                      reg_wdata,
    output logic [31:0]                      reg_rdata,
    input  logic [NUM_PINS*SRCS_PER_PIN-1:0] irq_in,
    output logic                             msg_valid,
    input  logic                             msg_ready,
    output logic [7:0]                       msg_vector,
    output logic [15:0]                      msg_dest,
    output logic [2:0]                       msg_dmode
);

    localparam int PW        = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam int IDX_LIMIT = int'(IDX_ENTRY_BASE) + 2 * NUM_PINS;
    localparam logic [31:0] VERSION_WORD = {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION};

    logic [7:0]          sel_q;
    logic                entry_hit;
    logic [PW-1:0]       sel_pin;
    logic                win_wr;
    logic                eoi_wr;
    logic [NUM_PINS-1:0] wr_low, wr_high, req, grant, take;
    logic [PW-1:0]       pick_idx;
    logic                pick_any;
    logic                load;
    logic [NUM_PINS-1:0] below_mask;
    rte_low_t            low_arr  [NUM_PINS];
    logic [15:0]         dest_arr [NUM_PINS];
    irq_msg_t            out_q;

    // ---------------- Indirect register access ----------------
    assign entry_hit = (sel_q >= IDX_ENTRY_BASE) && (int'(sel_q) < IDX_LIMIT);
    assign sel_pin   = PW'((sel_q - IDX_ENTRY_BASE) >> 1);
    assign win_wr    = reg_wr && (reg_addr == OFS_WINDOW) && entry_hit;
    assign eoi_wr    = reg_wr && (reg_addr == OFS_EOI);

    always_ff @(posedge clk) begin
        if (rst)                                   sel_q <= '0;
        else if (reg_wr && reg_addr == OFS_SELECT) sel_q <= reg_wdata[7:0];
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            if (reg_addr == OFS_SELECT) begin
                reg_rdata = {24'h0, sel_q};
            end else if (reg_addr == OFS_WINDOW) begin
                if (sel_q == IDX_VERSION)
                    reg_rdata = VERSION_WORD;
                else if (entry_hit)
                    reg_rdata = sel_q[0] ? {dest_arr[sel_pin], 16'h0}
                                         : pack_low(low_arr[sel_pin]);
            end
        end
    end

    // ---------------- Per-pin slots ----------------
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        assign wr_low[g]  = win_wr && !sel_q[0] && (sel_pin == PW'(g));
        assign wr_high[g] = win_wr &&  sel_q[0] && (sel_pin == PW'(g));

        irq_pin_slot #(.SRCS(SRCS_PER_PIN)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .src     (irq_in[g*SRCS_PER_PIN +: SRCS_PER_PIN]),
            .wr_low  (wr_low[g]),
            .wr_high (wr_high[g]),
            .wdata   (reg_wdata),
            .eoi_wr  (eoi_wr),
            .eoi_vec (reg_wdata[7:0]),
            .take    (take[g]),
            .low_q   (low_arr[g]),
            .dest_q  (dest_arr[g]),
            .req     (req[g])
        );
    end

    // ---------------- Arbitration and message output ----------------
    irq_lowest_pick #(.N(NUM_PINS), .IW(PW)) u_pick (
        .req   (req),
        .grant (grant),
        .idx   (pick_idx),
        .any   (pick_any)
    );

    assign load       = pick_any && (!msg_valid || msg_ready);
    assign take       = load ? grant : '0;
    assign below_mask = (NUM_PINS'(1) << pick_idx) - NUM_PINS'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid <= 1'b0;
            out_q     <= '0;
        end else if (load) begin
            msg_valid    <= 1'b1;
            out_q.vector <= low_arr[pick_idx].vector;
            out_q.dest   <= dest_arr[pick_idx];
            out_q.dmode  <= low_arr[pick_idx].dmode;
        end else if (msg_ready) begin
            msg_valid <= 1'b0;
        end
    end

    assign msg_vector = out_q.vector;
    assign msg_dest   = out_q.dest;
    assign msg_dmode  = out_q.dmode;

    // R1: no message in the first cycle after reset
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !msg_valid);

    // R4: a launch never comes from a masked pin
    p_launch_unmasked_r4: assert property (@(posedge clk) disable iff (rst)
        load |-> !low_arr[pick_idx].masked);

    // R9: a held message is stable
    p_hold_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(out_q)));

    // R10: no lower-numbered pin is requesting when a pin launches
    p_lowest_first_r10: assert property (@(posedge clk) disable iff (rst)
        load |-> ((req & below_mask) == '0));

endmodule

// File: tb/irq_redir_ctrl_tb.sv
module irq_redir_ctrl_tb;

    localparam int NP = 4;
    localparam int SP = 2;
    localparam logic [7:0] A_SEL = 8'h00;
    localparam logic [7:0] A_WIN = 8'h10;
    localparam logic [7:0] A_EOI = 8'h40;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]     reg_addr = '0;
    logic [31:0]    reg_wdata = '0, reg_rdata;
    logic [NP*SP-1:0] irq_in = '0;
    logic           msg_valid, msg_ready = 1'b0;
    logic [7:0]     msg_vector;
    logic [15:0]    msg_dest;
    logic [2:0]     msg_dmode;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irq_redir_ctrl #(.NUM_PINS(NP), .SRCS_PER_PIN(SP), .VERSION(8'h21)) u_dut (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_in(irq_in),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_vector(msg_vector), .msg_dest(msg_dest), .msg_dmode(msg_dmode)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic win_wr(input logic [7:0] idx, input logic [31:0] d);
        bus_wr(A_SEL, {24'h0, idx});
        bus_wr(A_WIN, d);
    endtask

    task automatic win_rd(input logic [7:0] idx, output logic [31:0] d);
        bus_wr(A_SEL, {24'h0, idx});
        bus_rd(A_WIN, d);
    endtask

    task automatic accept();
        @(negedge clk);
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic expect_msg(input string tag, input logic [7:0] v,
                              input logic [15:0] dst, input logic [2:0] dm);
        cycles(4);
        check({tag, " valid"}, {31'h0, msg_valid}, 32'h1);
        check({tag, " vector"}, {24'h0, msg_vector}, {24'h0, v});
        check({tag, " dest"}, {16'h0, msg_dest}, {16'h0, dst});
        check({tag, " dmode"}, {29'h0, msg_dmode}, {29'h0, dm});
    endtask

    task automatic expect_none(input string tag);
        cycles(4);
        check({tag, " no message"}, {31'h0, msg_valid}, 32'h0);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] pl, ph;
        cycles(3);
        rst = 1'b0;

        // R1: reset state of every entry and of the output
        check("R1 valid after reset", {31'h0, msg_valid}, 32'h0);
        for (int p = 0; p < NP; p++) begin
            win_rd(8'(8'h10 + 2*p), d);
            check("R1 low word reset", d, 32'h0001_0000);
            win_rd(8'(8'h11 + 2*p), d);
            check("R1 high word reset", d, 32'h0);
        end

        // R3: version word
        win_rd(8'h01, d);
        check("R3 version word", d, {8'h00, 8'(NP - 1), 8'h00, 8'h21});

        // R2: sweep every entry with patterns that set reserved bits
        for (int p = 0; p < NP; p++) begin
            pl = (32'hA5C3_F7E1 + 32'(p) * 32'h0102_0304) | 32'h0001_0000;
            ph = 32'h1234_5678 + 32'(p) * 32'h1111_1111;
            win_wr(8'(8'h10 + 2*p), pl);
            win_wr(8'(8'h11 + 2*p), ph);
            win_rd(8'(8'h10 + 2*p), d);
            check("R2 low word fields", d, pl & 32'h0001_A7FF);
            win_rd(8'(8'h11 + 2*p), d);
            check("R2 high word fields", d, ph & 32'hFFFF_0000);
        end
        bus_rd(A_SEL, d);
        check("R2 select readback", d, 32'(8'h11 + 2*(NP-1)));
        win_wr(8'(8'h10 + 2*NP), 32'hFFFF_FFFF);
        win_rd(8'(8'h10 + 2*NP), d);
        check("R2 unmapped index reads zero", d, 32'h0);
        win_rd(8'h00, d);
        check("R2 index zero reads zero", d, 32'h0);
        win_rd(8'h10, d);
        check("R2 unmapped write left pin0 alone", d, (32'hA5C3_F7E1 | 32'h0001_0000) & 32'h0001_A7FF);
        for (int p = 0; p < NP; p++) begin
            win_wr(8'(8'h10 + 2*p), 32'h0001_0000);
            win_wr(8'(8'h11 + 2*p), 32'h0);
        end

        // R4: read-modify-write of the mask bit only
        win_wr(8'h11, 32'hABCD_0000);
        win_wr(8'h10, 32'h0001_0340);
        win_rd(8'h10, d);
        win_wr(8'h10, d & ~32'h0001_0000);
        win_rd(8'h10, d);
        check("R4 unmask keeps other fields", d, 32'h0000_0340);

        // R5 / R8 / R9: edge on pin0, active-high
        irq_in[0] = 1'b1;
        expect_msg("R5 R8 edge delivery", 8'h40, 16'hABCD, 3'd3);
        cycles(5);
        check("R9 held valid", {31'h0, msg_valid}, 32'h1);
        check("R9 held vector", {24'h0, msg_vector}, 32'h40);
        accept();
        expect_none("R5 held level gives one edge only");
        irq_in[0] = 1'b0;
        cycles(2);
        irq_in[1] = 1'b1;
        expect_msg("R7 second source of pin0", 8'h40, 16'hABCD, 3'd3);
        accept();
        irq_in[1] = 1'b0;
        cycles(2);

        // R4 / R5: edge while masked is dropped
        win_wr(8'h10, 32'h0001_0340);
        irq_in[0] = 1'b1;
        expect_none("R4 masked pin silent");
        win_wr(8'h10, 32'h0000_0340);
        expect_none("R5 masked edge not replayed");
        irq_in[0] = 1'b0;
        cycles(2);
        win_wr(8'h10, 32'h0001_0340);

        // R6 / R7: level pin1, active-low, sources irq_in[3:2]
        irq_in[3:2] = 2'b11;
        win_wr(8'h13, 32'h0055_0000);
        win_wr(8'h12, 32'h0000_A151);
        expect_none("R7 active-low idle high");
        irq_in[2] = 1'b0;
        expect_msg("R7 R6 level active-low delivery", 8'h51, 16'h0055, 3'd1);
        accept();
        expect_none("R6 no redelivery before EOI");
        bus_wr(A_EOI, 32'h50);
        expect_none("R6 wrong EOI vector ignored");
        bus_wr(A_EOI, 32'h51);
        expect_msg("R6 redelivery after EOI", 8'h51, 16'h0055, 3'd1);
        accept();
        irq_in[2] = 1'b1;
        bus_wr(A_EOI, 32'h51);
        expect_none("R6 inactive after EOI");
        irq_in[3] = 1'b0;
        expect_msg("R7 other active-low source", 8'h51, 16'h0055, 3'd1);
        accept();
        irq_in[3] = 1'b1;
        bus_wr(A_EOI, 32'h51);
        win_wr(8'h12, 32'h0001_A151);

        // R10: two level pins asserted together
        win_wr(8'h14, 32'h0000_8062);
        win_wr(8'h16, 32'h0000_8273);
        @(negedge clk);
        irq_in[4] = 1'b1;
        irq_in[7] = 1'b1;
        expect_msg("R10 lowest pin first", 8'h62, 16'h0, 3'd0);
        accept();
        expect_msg("R10 higher pin follows", 8'h73, 16'h0, 3'd2);
        accept();
        expect_none("R10 both served");

        summary();
        $finish;
    end

endmodule